// File: doc/BRIEF.md
# BLAKE2s Compression Engine

This block runs the BLAKE2s compression function over a stream of 64-byte message blocks. It keeps the eight-word chaining value and the 64-bit byte counter in its own registers. A request names how many blocks follow and whether the last of them closes the message. The engine then takes the blocks one at a time through a valid/ready handshake. Before each block it adds 64 to the counter and builds the sixteen-word working vector from the current chain, the fixed initial words, the counter and the finalization word. After that it mixes for ten rounds and folds the result back into the chain. It does this for every block of the request with no help from the host, and pulses a done flag after the last one.

Mixing proceeds at one half-round per clock cycle. Four mixing lanes work side by side, on the columns in even steps and on the diagonals in odd steps. The host sets up the start state through a load port: the chaining value, derived from the parameter block, and a counter value. A host that must hash a short final block can preload the counter at the message length minus 64, so that the per-block increment lands on the true byte count. Key setup, padding and digest truncation belong to the host.

Top module: `blake2s_core`

## Requirements
- R1: After reset, `h_o` and `t_o` are zero, `idle_o` is 1, and `blk_ready_o` and `done_o` are 0.
- R2: While `idle_o` is 1, a cycle with `load_i` high writes `load_h_i` into the chain and `load_t_i` into the counter, and both are visible on `h_o`/`t_o` after that edge. When the engine is not idle, `load_i` has no effect.
- R3: When a block is accepted, the counter becomes its previous value plus 64, modulo 2^64, with the carry running from the low word into the high word. `t_o` shows the new value from the edge that accepts the block.
- R4: Each block updates the chain as a BLAKE2s compression. Word i of the chain is at bits [32i+31:32i] of `h_o`, and message word i is at bits [32i+31:32i] of `blk_data_i`, little-endian. The finalization word f0 is all-ones only for the last block of a request that was started with `start_final_i` = 1, and f1 is always zero.
- R5: For the 3-byte message "abc", with an unkeyed 32-byte-digest start state and a counter preloaded to 2^64-61, the chain after one final block equals the published BLAKE2s-256 digest.
- R6: A request of N blocks chains them back-to-back: each block is compressed on the chain and counter that the previous block left behind.
- R7: `blk_ready_o` is high only while an active request waits for its next block. After a block is accepted, `blk_ready_o` stays low, and `done_o` or the next `blk_ready_o` rises exactly 21 cycles after the accepting edge.
- R8: A request that names zero blocks pulses `done_o` in the next cycle and leaves the chain and the counter unchanged.
- R9: `start_i` is ignored while not idle, and `blk_valid_i` is ignored while no block is awaited. Neither changes `h_o`, `t_o` or the number of blocks the current request takes.
- R10: `done_o` is a one-cycle pulse. It coincides with `idle_o` returning to 1 after the last block of a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Write chain and counter (idle only) |
| load_h_i | input | 256 | Chain value to write, word i at bits 32i |
| load_t_i | input | 64 | Counter value to write |
| start_i | input | 1 | Begin a request (idle only) |
| start_blocks_i | input | CNT_W | Number of blocks in the request |
| start_final_i | input | 1 | Last block of the request ends the message |
| idle_o | output | 1 | No request in progress |
| blk_valid_i | input | 1 | Message block present |
| blk_data_i | input | 512 | Sixteen little-endian message words |
| blk_ready_o | output | 1 | Engine waits for a block |
| done_o | output | 1 | One-cycle pulse at the end of a request |
| h_o | output | 256 | Current chaining value |
| t_o | output | 64 | Current byte counter |

## Verification
The compression is driven with the "abc" vector, which pins down the constants, the permutation schedule, the rotation amounts and the f0 handling against a value the bench does not compute. A counter preload close to 2^64 forces the carry into the high word. Random chains and random blocks in multi-block requests, both final and non-final, separate correct chaining and f0 placement from mistakes that a single block would hide. Zero-block requests, blocks offered while idle, and load or start pulses sent in the middle of mixing show whether the control ignores what it must ignore. Block-to-done timing is counted on every block.

// File: rtl/blake2s_pkg.sv
package blake2s_pkg;
  localparam int WORD_W     = 32;
  localparam int H_WORDS    = 8;
  localparam int V_WORDS    = 16;
  localparam int M_WORDS    = 16;
  localparam int H_W        = WORD_W * H_WORDS;
  localparam int V_W        = WORD_W * V_WORDS;
  localparam int M_W        = WORD_W * M_WORDS;
  localparam int CTR_W      = 2 * WORD_W;
  localparam int BLK_BYTES  = M_W / 8;
  localparam int NUM_ROUNDS = 10;
  localparam int NUM_STEPS  = 2 * NUM_ROUNDS;
  localparam int STEP_W     = $clog2(NUM_STEPS);
  localparam int RND_W      = $clog2(NUM_ROUNDS);
  localparam int LANES      = 4;
  localparam int ROT_1      = 16;
  localparam int ROT_2      = 12;
  localparam int ROT_3      = 8;
  localparam int ROT_4      = 7;

  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_MIX, ST_FIN} state_e;

  function automatic word_t iv_word(input int unsigned idx);
    case (idx)
      0:       return 32'h6A09E667;
      1:       return 32'hBB67AE85;
      2:       return 32'h3C6EF372;
      3:       return 32'hA54FF53A;
      4:       return 32'h510E527F;
      5:       return 32'h9B05688C;
      6:       return 32'h1F83D9AB;
      default: return 32'h5BE0CD19;
    endcase
  endfunction

  function automatic word_t rotr(input word_t x, input int unsigned n);
    return (x >> n) | (x << (WORD_W - n));
  endfunction

  // nibble k of the row is the message index used at schedule position k
  function automatic logic [3:0] sigma_at(input logic [RND_W-1:0] rnd, input logic [3:0] pos);
    logic [63:0] row;
    case (rnd)
      4'd1:    row = 64'h357B20C16DF984AE;
      4'd2:    row = 64'h491763EADF250C8B;
      4'd3:    row = 64'h8F04A562EBCD1397;
      4'd4:    row = 64'hD386CB1EFA427509;
      4'd5:    row = 64'h91EF57D438B0A6C2;
      4'd6:    row = 64'hB8293670A4DEF15C;
      4'd7:    row = 64'hA2684F05931CE7BD;
      4'd8:    row = 64'h5A417D2C803B9EF6;
      4'd9:    row = 64'h0DC3E9BF5167482A;
      default: row = 64'hFEDCBA9876543210;
    endcase
    return row[pos*4 +: 4];
  endfunction
endpackage

// File: rtl/blake2s_g.sv
module blake2s_g
  import blake2s_pkg::*;
(
  input  word_t a_i,
  input  word_t b_i,
  input  word_t c_i,
  input  word_t d_i,
  input  word_t mx_i,
  input  word_t my_i,
  output word_t a_o,
  output word_t b_o,
  output word_t c_o,
  output word_t d_o
);
  word_t a1, b1, c1, d1;

  always_comb begin
    a1  = a_i + b_i + mx_i;
    d1  = rotr(d_i ^ a1, ROT_1);
    c1  = c_i + d1;
    b1  = rotr(b_i ^ c1, ROT_2);
    a_o = a1 + b1 + my_i;
    d_o = rotr(d1 ^ a_o, ROT_3);
    c_o = c1 + d_o;
    b_o = rotr(b1 ^ c_o, ROT_4);
  end
endmodule

// File: rtl/blake2s_half_round.sv
module blake2s_half_round
  import blake2s_pkg::*;
(
  input  logic [V_W-1:0]   v_i,
  input  logic [M_W-1:0]   m_i,
  input  logic [RND_W-1:0] round_i,
  input  logic             diag_i,
  output logic [V_W-1:0]   v_o
);
  word_t ga [LANES];
  word_t gb [LANES];
  word_t gc [LANES];
  word_t gd [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam int IA  = g;
    localparam int IBC = LANES + g;
    localparam int IBD = LANES + ((g + 1) % LANES);
    localparam int ICC = 2*LANES + g;
    localparam int ICD = 2*LANES + ((g + 2) % LANES);
    localparam int IDC = 3*LANES + g;
    localparam int IDD = 3*LANES + ((g + 3) % LANES);

    word_t a_in, b_in, c_in, d_in, mx, my;
    logic [3:0] px, py;

    assign a_in = v_i[WORD_W*IA +: WORD_W];
    assign b_in = diag_i ? v_i[WORD_W*IBD +: WORD_W] : v_i[WORD_W*IBC +: WORD_W];
    assign c_in = diag_i ? v_i[WORD_W*ICD +: WORD_W] : v_i[WORD_W*ICC +: WORD_W];
    assign d_in = diag_i ? v_i[WORD_W*IDD +: WORD_W] : v_i[WORD_W*IDC +: WORD_W];

    // column step uses schedule slots 0..7, diagonal step 8..15
    assign px = sigma_at(round_i, {diag_i, 2'(g), 1'b0});
    assign py = sigma_at(round_i, {diag_i, 2'(g), 1'b1});
    assign mx = m_i[WORD_W*px +: WORD_W];
    assign my = m_i[WORD_W*py +: WORD_W];

    blake2s_g u_g (
      .a_i (a_in), .b_i (b_in), .c_i (c_in), .d_i (d_in),
      .mx_i(mx),   .my_i(my),
      .a_o (ga[g]), .b_o (gb[g]), .c_o (gc[g]), .d_o (gd[g])
    );
  end

  // put lane results back where they were taken from
  always_comb begin
    for (int j = 0; j < LANES; j++) begin
      v_o[WORD_W*j +: WORD_W]             = ga[j];
      v_o[WORD_W*(LANES+j) +: WORD_W]     = diag_i ? gb[(j+3)%LANES] : gb[j];
      v_o[WORD_W*(2*LANES+j) +: WORD_W]   = diag_i ? gc[(j+2)%LANES] : gc[j];
      v_o[WORD_W*(3*LANES+j) +: WORD_W]   = diag_i ? gd[(j+1)%LANES] : gd[j];
    end
  end
endmodule

// File: rtl/blake2s_ctrl.sv
module blake2s_ctrl
  import blake2s_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] blocks_i,
  input  logic             final_i,
  input  logic             load_i,
  input  logic             blk_valid_i,
  output logic             idle_o,
  output logic             blk_ready_o,
  output logic             done_o,
  output logic             accept_o,
  output logic             mix_o,
  output logic             fin_o,
  output logic             load_ok_o,
  output logic             last_blk_o,
  output logic [RND_W-1:0] round_o,
  output logic             diag_o
);
  state_e              state_q;
  logic [STEP_W-1:0]   step_q;
  logic [CNT_W-1:0]    rem_q;
  logic                final_q;
  logic                done_q;

  assign idle_o      = (state_q == ST_IDLE);
  assign blk_ready_o = (state_q == ST_WAIT);
  assign accept_o    = blk_ready_o && blk_valid_i;
  assign mix_o       = (state_q == ST_MIX);
  assign fin_o       = (state_q == ST_FIN);
  assign load_ok_o   = idle_o && load_i;
  assign last_blk_o  = final_q && (rem_q == CNT_W'(1));
  assign round_o     = step_q[STEP_W-1:1];
  assign diag_o      = step_q[0];
  assign done_o      = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
      rem_q   <= '0;
      final_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (start_i) begin
          if (blocks_i == '0) begin
            done_q <= 1'b1;
          end else begin
            state_q <= ST_WAIT;
            rem_q   <= blocks_i;
            final_q <= final_i;
          end
        end
        ST_WAIT: if (blk_valid_i) begin
          state_q <= ST_MIX;
          step_q  <= '0;
        end
        ST_MIX: begin
          if (step_q == STEP_W'(NUM_STEPS - 1)) state_q <= ST_FIN;
          else                                   step_q  <= step_q + 1'b1;
        end
        default: begin
          rem_q <= rem_q - 1'b1;
          if (rem_q == CNT_W'(1)) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end else begin
            state_q <= ST_WAIT;
          end
        end
      endcase
    end
  end

  p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);

  p_zero_req_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_o && start_i && blocks_i == '0) |=> (done_q && idle_o));

  p_ready_drop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |=> !blk_ready_o);

  p_step_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mix_o |-> (step_q < STEP_W'(NUM_STEPS)));

  p_mix_to_fin_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mix_o && step_q == STEP_W'(NUM_STEPS - 1)) |=> fin_o);

  p_busy_start_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!idle_o && !fin_o) |=> $stable(rem_q));
endmodule

// File: rtl/blake2s_core.sv
module blake2s_core
  import blake2s_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [255:0]     load_h_i,
  input  logic [63:0]      load_t_i,
  input  logic             start_i,
  input  logic [CNT_W-1:0] start_blocks_i,
  input  logic             start_final_i,
  output logic             idle_o,
  input  logic             blk_valid_i,
  input  logic [511:0]     blk_data_i,
  output logic             blk_ready_o,
  output logic             done_o,
  output logic [255:0]     h_o,
  output logic [63:0]      t_o
);
  logic [H_W-1:0]   h_q;
  logic [CTR_W-1:0] t_q;
  logic [V_W-1:0]   v_q;
  logic [M_W-1:0]   m_q;

  logic             accept, mix, fin, load_ok, last_blk, diag;
  logic [RND_W-1:0] round;
  logic [CTR_W-1:0] t_inc;
  logic [V_W-1:0]   v_init, v_mix;
  logic [H_W-1:0]   h_new;

  blake2s_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .blocks_i   (start_blocks_i),
    .final_i    (start_final_i),
    .load_i     (load_i),
    .blk_valid_i(blk_valid_i),
    .idle_o     (idle_o),
    .blk_ready_o(blk_ready_o),
    .done_o     (done_o),
    .accept_o   (accept),
    .mix_o      (mix),
    .fin_o      (fin),
    .load_ok_o  (load_ok),
    .last_blk_o (last_blk),
    .round_o    (round),
    .diag_o     (diag)
  );

  blake2s_half_round u_half (
    .v_i    (v_q),
    .m_i    (m_q),
    .round_i(round),
    .diag_i (diag),
    .v_o    (v_mix)
  );

  assign t_inc = t_q + CTR_W'(BLK_BYTES);

  always_comb begin
    for (int i = 0; i < H_WORDS; i++) begin
      v_init[WORD_W*i +: WORD_W]           = h_q[WORD_W*i +: WORD_W];
      v_init[WORD_W*(H_WORDS+i) +: WORD_W] = iv_word(i);
    end
    v_init[WORD_W*12 +: WORD_W] = iv_word(4) ^ t_inc[WORD_W-1:0];
    v_init[WORD_W*13 +: WORD_W] = iv_word(5) ^ t_inc[CTR_W-1:WORD_W];
    v_init[WORD_W*14 +: WORD_W] = iv_word(6) ^ {WORD_W{last_blk}};
  end

  always_comb begin
    for (int i = 0; i < H_WORDS; i++) begin
      h_new[WORD_W*i +: WORD_W] = h_q[WORD_W*i +: WORD_W]
                                ^ v_q[WORD_W*i +: WORD_W]
                                ^ v_q[WORD_W*(H_WORDS+i) +: WORD_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h_q <= '0;
      t_q <= '0;
      v_q <= '0;
      m_q <= '0;
    end else begin
      if (load_ok) begin
        h_q <= load_h_i;
        t_q <= load_t_i;
      end
      if (accept) begin
        t_q <= t_inc;
        v_q <= v_init;
        m_q <= blk_data_i;
      end
      if (mix) v_q <= v_mix;
      if (fin) h_q <= h_new;
    end
  end

  assign h_o = h_q;
  assign t_o = t_q;

  p_cnt_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> (t_q == $past(t_q) + 64'd64));

  p_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_ok |=> (h_q == $past(load_h_i) && t_q == $past(load_t_i)));

  p_h_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fin || load_ok) |=> $stable(h_q));

  p_msg_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mix |=> $stable(m_q));
endmodule

// File: tb/blake2s_core_tb_top.sv
module blake2s_core_tb_top;
  localparam int CNT_W = 16;

  logic             clk_i = 1'b0;
  logic             rst_ni;
  logic             load_i;
  logic [255:0]     load_h_i;
  logic [63:0]      load_t_i;
  logic             start_i;
  logic [CNT_W-1:0] start_blocks_i;
  logic             start_final_i;
  logic             idle_o;
  logic             blk_valid_i;
  logic [511:0]     blk_data_i;
  logic             blk_ready_o;
  logic             done_o;
  logic [255:0]     h_o;
  logic [63:0]      t_o;

  always #4 clk_i = ~clk_i;

  blake2s_core #(.CNT_W(CNT_W)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .load_i(load_i), .load_h_i(load_h_i), .load_t_i(load_t_i),
    .start_i(start_i), .start_blocks_i(start_blocks_i), .start_final_i(start_final_i),
    .idle_o(idle_o), .blk_valid_i(blk_valid_i), .blk_data_i(blk_data_i),
    .blk_ready_o(blk_ready_o), .done_o(done_o), .h_o(h_o), .t_o(t_o)
  );

  int checks = 0;
  int errors = 0;
  logic [255:0] exp_h;
  logic [63:0]  exp_t;

  function automatic logic [31:0] rr(logic [31:0] x, int n);
    return (x >> n) | (x << (32 - n));
  endfunction

  function automatic logic [31:0] ivw(int i);
    case (i)
      0: return 32'h6A09E667; 1: return 32'hBB67AE85;
      2: return 32'h3C6EF372; 3: return 32'hA54FF53A;
      4: return 32'h510E527F; 5: return 32'h9B05688C;
      6: return 32'h1F83D9AB; default: return 32'h5BE0CD19;
    endcase
  endfunction

  function automatic logic [63:0] perm(int r);
    case (r)
      1: return 64'h357B20C16DF984AE; 2: return 64'h491763EADF250C8B;
      3: return 64'h8F04A562EBCD1397; 4: return 64'hD386CB1EFA427509;
      5: return 64'h91EF57D438B0A6C2; 6: return 64'hB8293670A4DEF15C;
      7: return 64'hA2684F05931CE7BD; 8: return 64'h5A417D2C803B9EF6;
      9: return 64'h0DC3E9BF5167482A; default: return 64'hFEDCBA9876543210;
    endcase
  endfunction

  function automatic logic [255:0] ref_compress(logic [255:0] h, logic [511:0] m,
                                                logic [63:0] t, bit last);
    logic [31:0] v [16];
    logic [31:0] mw [16];
    logic [255:0] res;
    for (int i = 0; i < 8; i++) begin
      v[i] = h[32*i +: 32];
      v[8+i] = ivw(i);
    end
    for (int i = 0; i < 16; i++) mw[i] = m[32*i +: 32];
    v[12] ^= t[31:0];
    v[13] ^= t[63:32];
    if (last) v[14] = ~v[14];
    for (int r = 0; r < 10; r++) begin
      for (int gi = 0; gi < 8; gi++) begin
        int a, b, c, d, j;
        logic [63:0] p;
        logic [31:0] x, y;
        p = perm(r);
        x = mw[p[8*gi +: 4]];
        y = mw[p[8*gi+4 +: 4]];
        j = gi % 4;
        if (gi < 4) begin
          a = j; b = 4 + j; c = 8 + j; d = 12 + j;
        end else begin
          a = j; b = 4 + ((j+1) & 3); c = 8 + ((j+2) & 3); d = 12 + ((j+3) & 3);
        end
        v[a] = v[a] + v[b] + x;  v[d] = rr(v[d] ^ v[a], 16);
        v[c] = v[c] + v[d];      v[b] = rr(v[b] ^ v[c], 12);
        v[a] = v[a] + v[b] + y;  v[d] = rr(v[d] ^ v[a], 8);
        v[c] = v[c] + v[d];      v[b] = rr(v[b] ^ v[c], 7);
      end
    end
    for (int i = 0; i < 8; i++) res[32*i +: 32] = h[32*i +: 32] ^ v[i] ^ v[i+8];
    return res;
  endfunction

  function automatic logic [511:0] rnd_blk();
    logic [511:0] r;
    for (int i = 0; i < 16; i++) r[32*i +: 32] = $urandom;
    return r;
  endfunction

  function automatic logic [255:0] rnd_h();
    logic [255:0] r;
    for (int i = 0; i < 8; i++) r[32*i +: 32] = $urandom;
    return r;
  endfunction

  task automatic tick();
    @(posedge clk_i);
    #1;
  endtask

  task automatic chk(bit ok, string what, logic [255:0] act, logic [255:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", what, act, exp);
    end
  endtask

  task automatic do_load(logic [255:0] h, logic [63:0] t);
    load_i = 1'b1; load_h_i = h; load_t_i = t;
    tick();
    load_i = 1'b0;
    exp_h = h; exp_t = t;
    chk(h_o == exp_h && t_o == exp_t, "R2 load visible", {h_o ^ exp_h}, {192'd0, exp_t});
  endtask

  task automatic feed_block(logic [511:0] m, bit last, bit poke, string tag);
    int w;
    int cyc;
    w = 0;
    while (!blk_ready_o && w < 200) begin tick(); w++; end
    chk(blk_ready_o, "R7 ready awaited", {255'd0, blk_ready_o}, 256'd1);
    blk_valid_i = 1'b1; blk_data_i = m;
    tick();
    blk_valid_i = 1'b0; blk_data_i = rnd_blk();
    exp_t += 64'd64;
    chk(t_o == exp_t, "R3 counter step", {192'd0, t_o}, {192'd0, exp_t});
    exp_h = ref_compress(exp_h, m, exp_t, last);
    cyc = 0;
    while (!(done_o || blk_ready_o) && cyc < 100) begin
      if (poke && cyc == 5) begin
        load_i = 1'b1; load_h_i = rnd_h(); load_t_i = {$urandom, $urandom};
        start_i = 1'b1; start_blocks_i = CNT_W'(5); start_final_i = 1'b0;
      end
      tick();
      cyc++;
      load_i = 1'b0; start_i = 1'b0;
    end
    chk(cyc == 21, "R7 block latency", 256'(cyc), 256'd21);
    chk(h_o == exp_h, tag, h_o, exp_h);
    chk(t_o == exp_t, "R9 counter untouched by busy load", {192'd0, t_o}, {192'd0, exp_t});
  endtask

  task automatic run_req(int n, bit fin, bit poke, string tag);
    start_i = 1'b1; start_blocks_i = CNT_W'(n); start_final_i = fin;
    tick();
    start_i = 1'b0;
    for (int k = 0; k < n; k++) feed_block(rnd_blk(), fin && (k == n-1), poke && (k == 0), tag);
    chk(done_o && idle_o, "R10 done with idle", {254'd0, done_o, idle_o}, 256'd3);
    tick();
    chk(!done_o && idle_o && !blk_ready_o, "R10 single pulse / R9 no extra blocks",
        {253'd0, done_o, idle_o, blk_ready_o}, 256'd2);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    checks++;
    errors++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [255:0] abc_h, abc_dig;
    logic [511:0] abc_m;
    void'($urandom(32'd20240611));
    rst_ni = 1'b0; load_i = 1'b0; load_h_i = '0; load_t_i = '0;
    start_i = 1'b0; start_blocks_i = '0; start_final_i = 1'b0;
    blk_valid_i = 1'b0; blk_data_i = '0;
    exp_h = '0; exp_t = '0;
    repeat (3) tick();
    rst_ni = 1'b1;
    tick();

    // R1 reset state
    chk(h_o == '0 && t_o == '0, "R1 reset chain/counter", h_o, 256'd0);
    chk(idle_o && !blk_ready_o && !done_o, "R1 reset flags",
        {253'd0, idle_o, blk_ready_o, done_o}, 256'd4);

    // R9 block offered while idle
    blk_valid_i = 1'b1; blk_data_i = rnd_blk();
    repeat (3) tick();
    blk_valid_i = 1'b0;
    chk(!blk_ready_o && idle_o && h_o == '0 && t_o == '0, "R9 idle block ignored", h_o, 256'd0);

    // R5 known digest of "abc"
    for (int i = 0; i < 8; i++) abc_h[32*i +: 32] = ivw(i);
    abc_h[31:0] ^= 32'h01010020;
    abc_m = '0;
    abc_m[31:0] = 32'h00636261;
    abc_dig = {32'h82596786, 32'h4C9B994D, 32'h293AD69E, 32'h208B4537,
               32'h2F45EB4E, 32'hA32BA7E1, 32'hE2147C32, 32'h8C5E8C50};
    do_load(abc_h, 64'hFFFF_FFFF_FFFF_FFC3);
    start_i = 1'b1; start_blocks_i = CNT_W'(1); start_final_i = 1'b1;
    tick();
    start_i = 1'b0;
    feed_block(abc_m, 1'b1, 1'b0, "R4 abc model");
    chk(t_o == 64'd3, "R3 counter carry wrap", {192'd0, t_o}, 256'd3);
    chk(h_o == abc_dig, "R5 abc digest", h_o, abc_dig);
    chk(done_o && idle_o, "R10 abc done", {254'd0, done_o, idle_o}, 256'd3);
    tick();

    // R6 multi-block final request from random chain
    do_load(rnd_h(), 64'd0);
    run_req(3, 1'b1, 1'b0, "R6 three-block chain");

    // R4 non-final request continues the chain, f0 stays zero
    run_req(2, 1'b0, 1'b0, "R4 non-final blocks");

    // R8 zero-block request
    start_i = 1'b1; start_blocks_i = '0; start_final_i = 1'b1;
    tick();
    start_i = 1'b0;
    chk(done_o && idle_o, "R8 zero request done", {254'd0, done_o, idle_o}, 256'd3);
    chk(h_o == exp_h && t_o == exp_t, "R8 state unchanged", h_o, exp_h);
    tick();
    chk(!done_o, "R10 zero request pulse", {255'd0, done_o}, 256'd0);

    // R9 and R2: load/start pulsed while mixing
    run_req(2, 1'b1, 1'b1, "R9 busy pokes ignored");

    // random requests, counter near low-word carry
    for (int it = 0; it < 5; it++) begin
      int n;
      bit fin;
      n = 1 + int'($urandom % 3);
      fin = 1'($urandom % 2);
      if (it % 2 == 0) do_load(rnd_h(), {$urandom, 32'hFFFF_FFC0 | ($urandom & 32'h3F)});
      run_req(n, fin, 1'b0, "R6 random chain");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule